// File: doc/BRIEF.md
# Outstanding Transaction Tracker with Completion Queue

This block keeps a small table of in-flight coherence transactions, one entry per outstanding miss or writeback, each addressed by a slot number. When an entry is opened it records the line address, a transient state code, a snapshot of the line data and its dirty flag, and it starts a signed message counter at zero. The snapshot lets the owner keep answering forwarded requests while a writeback is in flight. At writeback time the snapshot's dirty flag picks between a writeback that carries the data and a clean writeback without it.

Each arriving response, or a forwarded copy of the cache's own exclusive request, updates one entry. The message's signed ack field is subtracted from the counter, so a plain acknowledgement from a peer cache (ack field -1) raises the counter by one. A data reply that announces N expected acknowledgements lowers it by N. When an update leaves the counter at exactly zero, the block does not close the entry itself. It posts an all-acks notice carrying the line address into an in-order trigger queue, and the controller pops notices from that queue.

Top module: `txn_tracker`

## Requirements
- R1: After reset every slot is free (`rd_valid` low for every `rd_slot`), `trig_valid` is low and `alloc_stall` is low.
- R2: When `alloc_req` is high and a slot is free, the lowest-numbered free slot is shown on `alloc_slot` in that cycle. From the next cycle that slot is valid and holds the given address, state, data and dirty flag, with a count of zero.
- R3: When `alloc_req` is high and no slot is free, `alloc_stall` is high in that cycle and no entry changes.
- R4: An update (`upd_valid`) to a valid slot replaces its count with count minus the signed `upd_acks` field. An ack of -1 therefore raises the count by one. An update to a free slot is ignored.
- R5: An update whose result is exactly zero enqueues one notice carrying that entry's address. The notice is visible from the next cycle. Any other result enqueues nothing.
- R6: `trig_valid` is high whenever the queue holds a notice, and `trig_addr` shows the oldest notice. `trig_pop` removes it. Notices leave in the order they were enqueued, and a pop on an empty queue is ignored.
- R7: `dealloc_valid` frees the slot from the next cycle. When an update and a deallocate name the same slot in one cycle, `coll_err` is high in that cycle, the deallocate takes effect and the update is dropped, so no notice is posted.
- R8: `rd_wb_kind` for the slot on `rd_slot` is 2'b10 (writeback with data) when the entry is valid and dirty, 2'b01 (clean writeback) when it is valid and clean, and 2'b00 when the slot is free.
- R9: A state write (`st_wr_valid`) to a valid slot replaces its transient state from the next cycle. A state write to a free slot is ignored.
- R10: The count is a 6-bit two's-complement value that wraps: 31 minus an ack of -1 gives -32.
- R11: A slot freed in a cycle cannot be granted in that same cycle. It can be granted from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Open an entry |
| alloc_addr | input | ADDR_W | Line address for the new entry |
| alloc_state | input | STATE_W | Initial transient state |
| alloc_data | input | DATA_W | Line data snapshot |
| alloc_dirty | input | 1 | Dirty flag snapshot |
| alloc_slot | output | SLOT_W | Slot granted this cycle (lowest free) |
| alloc_stall | output | 1 | Request refused, table full |
| upd_valid | input | 1 | Apply a message to a slot |
| upd_slot | input | SLOT_W | Slot updated |
| upd_acks | input | CNT_W | Signed ack field of the message |
| st_wr_valid | input | 1 | Write a new transient state |
| st_wr_slot | input | SLOT_W | Slot whose state is written |
| st_wr_state | input | STATE_W | New state |
| dealloc_valid | input | 1 | Free a slot |
| dealloc_slot | input | SLOT_W | Slot freed |
| coll_err | output | 1 | Update and deallocate hit one slot |
| rd_slot | input | SLOT_W | Slot shown on the read outputs |
| rd_valid | output | 1 | Slot is in use |
| rd_addr | output | ADDR_W | Entry address |
| rd_state | output | STATE_W | Entry transient state |
| rd_data | output | DATA_W | Entry data snapshot |
| rd_count | output | CNT_W | Signed outstanding-message count |
| rd_wb_kind | output | 2 | Writeback kind code |
| trig_valid | output | 1 | A notice is waiting |
| trig_addr | output | ADDR_W | Address of the oldest notice |
| trig_pop | input | 1 | Remove the oldest notice |

## Verification
The assertions assume that a notice never arrives while the trigger queue is already full, because such a notice would be lost. That assumption is itself checked as a property. The stimulus pops notices often enough that no more than a few are ever queued, which keeps the queue well below its depth. Updates that drive a count to zero are only issued to valid slots, and every collision case in the stimulus names a slot that is in use.

// File: rtl/txn_tracker.sv
module txn_tracker #(
  parameter int SLOTS      = 4,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int STATE_W    = 4,
  parameter int CNT_W      = 6,
  parameter int TRIG_DEPTH = 8,
  localparam int SLOT_W    = $clog2(SLOTS),
  localparam int TP_W      = $clog2(TRIG_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_req,
  input  logic [ADDR_W-1:0]        alloc_addr,
  input  logic [STATE_W-1:0]       alloc_state,
  input  logic [DATA_W-1:0]        alloc_data,
  input  logic                     alloc_dirty,
  output logic [SLOT_W-1:0]        alloc_slot,
  output logic                     alloc_stall,
  input  logic                     upd_valid,
  input  logic [SLOT_W-1:0]        upd_slot,
  input  logic signed [CNT_W-1:0]  upd_acks,
  input  logic                     st_wr_valid,
  input  logic [SLOT_W-1:0]        st_wr_slot,
  input  logic [STATE_W-1:0]       st_wr_state,
  input  logic                     dealloc_valid,
  input  logic [SLOT_W-1:0]        dealloc_slot,
  output logic                     coll_err,
  input  logic [SLOT_W-1:0]        rd_slot,
  output logic                     rd_valid,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic [STATE_W-1:0]       rd_state,
  output logic [DATA_W-1:0]        rd_data,
  output logic signed [CNT_W-1:0]  rd_count,
  output logic [1:0]               rd_wb_kind,
  output logic                     trig_valid,
  output logic [ADDR_W-1:0]        trig_addr,
  input  logic                     trig_pop
);

  logic [SLOTS-1:0]          valid_q;
  logic [ADDR_W-1:0]         addr_q  [SLOTS];
  logic [STATE_W-1:0]        state_q [SLOTS];
  logic [DATA_W-1:0]         data_q  [SLOTS];
  logic [SLOTS-1:0]          dirty_q;
  logic signed [CNT_W-1:0]   cnt_q   [SLOTS];

  logic [ADDR_W-1:0]         fifo_q  [TRIG_DEPTH];
  logic [TP_W-1:0]           wp_q, rp_q;
  logic [TP_W:0]             fifo_cnt;

  logic [SLOT_W-1:0]         free_idx;
  logic                      any_free;
  logic                      alloc_go, upd_hit, push, do_push, do_pop;
  logic signed [CNT_W-1:0]   cnt_next;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        free_idx = SLOT_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign alloc_slot  = free_idx;
  assign alloc_stall = alloc_req & ~any_free;
  assign alloc_go    = alloc_req & any_free;

  assign coll_err = upd_valid & dealloc_valid & (upd_slot == dealloc_slot);
  assign upd_hit  = upd_valid & valid_q[upd_slot] & ~coll_err;
  assign cnt_next = cnt_q[upd_slot] - upd_acks;
  assign push     = upd_hit & (cnt_next == '0);
  assign do_push  = push & (fifo_cnt != (TP_W+1)'(TRIG_DEPTH));
  assign do_pop   = trig_pop & (fifo_cnt != '0);

  assign rd_valid   = valid_q[rd_slot];
  assign rd_addr    = addr_q[rd_slot];
  assign rd_state   = state_q[rd_slot];
  assign rd_data    = data_q[rd_slot];
  assign rd_count   = cnt_q[rd_slot];
  assign rd_wb_kind = !rd_valid ? 2'b00 : (dirty_q[rd_slot] ? 2'b10 : 2'b01);

  assign trig_valid = (fifo_cnt != '0);
  assign trig_addr  = fifo_q[rp_q];

  function automatic logic [TP_W-1:0] ptr_inc(input logic [TP_W-1:0] p);
    return (p == TP_W'(TRIG_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        addr_q[i]  <= '0;
        state_q[i] <= '0;
        data_q[i]  <= '0;
        cnt_q[i]   <= '0;
      end
    end else begin
      if (st_wr_valid && valid_q[st_wr_slot])
        state_q[st_wr_slot] <= st_wr_state;
      if (upd_hit)
        cnt_q[upd_slot] <= cnt_next;
      if (dealloc_valid)
        valid_q[dealloc_slot] <= 1'b0;
      if (alloc_go) begin
        valid_q[free_idx] <= 1'b1;
        addr_q[free_idx]  <= alloc_addr;
        state_q[free_idx] <= alloc_state;
        data_q[free_idx]  <= alloc_data;
        dirty_q[free_idx] <= alloc_dirty;
        cnt_q[free_idx]   <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q     <= '0;
      rp_q     <= '0;
      fifo_cnt <= '0;
      for (int i = 0; i < TRIG_DEPTH; i++) fifo_q[i] <= '0;
    end else begin
      if (do_push) begin
        fifo_q[wp_q] <= addr_q[upd_slot];
        wp_q         <= ptr_inc(wp_q);
      end
      if (do_pop) rp_q <= ptr_inc(rp_q);
      fifo_cnt <= fifo_cnt + (TP_W+1)'(do_push) - (TP_W+1)'(do_pop);
    end
  end

endmodule

module txn_tracker_chk #(
  parameter int SLOTS      = 4,
  parameter int TRIG_DEPTH = 8,
  localparam int SLOT_W    = $clog2(SLOTS),
  localparam int TP_W      = $clog2(TRIG_DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_req,
  input logic              alloc_stall,
  input logic [SLOT_W-1:0] alloc_slot,
  input logic              dealloc_valid,
  input logic [SLOT_W-1:0] dealloc_slot,
  input logic              coll_err,
  input logic [SLOTS-1:0]  valid_q,
  input logic [TP_W:0]     fifo_cnt,
  input logic              push
);

  a_r3_stall_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_stall && !dealloc_valid) |=> (valid_q == $past(valid_q)));

  a_r2_grant_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !alloc_stall) |=> valid_q[$past(alloc_slot)]);

  a_r7_dealloc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    coll_err |=> !valid_q[$past(dealloc_slot)]);

  a_r6_queue_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fifo_cnt == $past(fifo_cnt) || fifo_cnt == $past(fifo_cnt) + 1'b1
              || fifo_cnt + 1'b1 == $past(fifo_cnt)));

  a_r6_room: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (fifo_cnt < (TP_W+1)'(TRIG_DEPTH)));

  a_r11_busy_not_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !alloc_stall) |-> !valid_q[alloc_slot]);

endmodule

bind txn_tracker txn_tracker_chk #(.SLOTS(SLOTS), .TRIG_DEPTH(TRIG_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_stall(alloc_stall),
  .alloc_slot(alloc_slot), .dealloc_valid(dealloc_valid), .dealloc_slot(dealloc_slot),
  .coll_err(coll_err), .valid_q(valid_q), .fifo_cnt(fifo_cnt), .push(push)
);

// File: tb/tb_txn_tracker.sv
module tb_txn_tracker;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic alloc_req = 0, alloc_dirty = 0;
  logic [15:0] alloc_addr = 0;
  logic [3:0] alloc_state = 0;
  logic [31:0] alloc_data = 0;
  logic [1:0] alloc_slot;
  logic alloc_stall;
  logic upd_valid = 0;
  logic [1:0] upd_slot = 0;
  logic signed [5:0] upd_acks = 0;
  logic st_wr_valid = 0;
  logic [1:0] st_wr_slot = 0;
  logic [3:0] st_wr_state = 0;
  logic dealloc_valid = 0;
  logic [1:0] dealloc_slot = 0;
  logic coll_err;
  logic [1:0] rd_slot = 0;
  logic rd_valid;
  logic [15:0] rd_addr;
  logic [3:0] rd_state;
  logic [31:0] rd_data;
  logic signed [5:0] rd_count;
  logic [1:0] rd_wb_kind;
  logic trig_valid;
  logic [15:0] trig_addr;
  logic trig_pop = 0;

  always #(PERIOD/2) clk = ~clk;

  txn_tracker dut (.*);

  int checks = 0, fails = 0;
  bit m_valid [4];
  int m_addr [4], m_state [4], m_data [4];
  bit m_dirty [4];
  logic signed [5:0] m_cnt [4];
  int q [$];

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare();
    int fi = -1;
    bit cl;
    for (int i = 3; i >= 0; i--) if (!m_valid[i]) fi = i;
    chk("R3", alloc_stall, alloc_req && fi < 0);
    if (fi >= 0) chk("R2", alloc_slot, fi);
    chk("R6", trig_valid, q.size() != 0);
    if (q.size() != 0) chk("R6", trig_addr, q[0]);
    cl = upd_valid && dealloc_valid && upd_slot == dealloc_slot;
    chk("R7", coll_err, cl);
    chk("R7", rd_valid, m_valid[rd_slot]);
    if (m_valid[rd_slot]) begin
      chk("R2", rd_addr, m_addr[rd_slot]);
      chk("R2", rd_data, m_data[rd_slot]);
      chk("R9", rd_state, m_state[rd_slot]);
      chk("R4", rd_count, m_cnt[rd_slot]);
      chk("R8", rd_wb_kind, m_dirty[rd_slot] ? 2 : 1);
    end else chk("R8", rd_wb_kind, 0);
  endtask

  task automatic model_update();
    int fi = -1;
    bit cl;
    logic signed [5:0] c;
    for (int i = 3; i >= 0; i--) if (!m_valid[i]) fi = i;
    cl = upd_valid && dealloc_valid && upd_slot == dealloc_slot;
    if (trig_pop && q.size() > 0) void'(q.pop_front());
    if (upd_valid && m_valid[upd_slot] && !cl) begin
      c = m_cnt[upd_slot] - upd_acks;
      m_cnt[upd_slot] = c;
      if (c == 0) q.push_back(m_addr[upd_slot]);
    end
    if (st_wr_valid && m_valid[st_wr_slot]) m_state[st_wr_slot] = st_wr_state;
    if (dealloc_valid) m_valid[dealloc_slot] = 0;
    if (alloc_req && fi >= 0) begin
      m_valid[fi] = 1; m_addr[fi] = alloc_addr; m_state[fi] = alloc_state;
      m_data[fi] = alloc_data; m_dirty[fi] = alloc_dirty; m_cnt[fi] = 0;
    end
  endtask

  task automatic step();
    #1 compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
    alloc_req = 0; upd_valid = 0; st_wr_valid = 0; dealloc_valid = 0; trig_pop = 0;
  endtask

  task automatic do_alloc(int a, int st, int d, bit dy);
    alloc_req = 1; alloc_addr = 16'(a); alloc_state = 4'(st);
    alloc_data = 32'(d); alloc_dirty = dy;
    step();
  endtask

  task automatic do_upd(int s, int acks);
    upd_valid = 1; upd_slot = 2'(s); upd_acks = 6'(acks);
    rd_slot = 2'(s);
    step();
  endtask

  task automatic show_all();
    for (int i = 0; i < 4; i++) begin rd_slot = 2'(i); step(); end
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_valid[i] = 0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd_slot = 2'(i); #1;
      chk("R1", rd_valid, 0);
      chk("R1", trig_valid, 0);
      chk("R1", alloc_stall, 0);
      @(negedge clk);
    end
    // R2 fill table, R8 mixed dirty
    do_alloc('h1100, 3, 'hA0A0, 1);
    do_alloc('h2200, 5, 'hB1B1, 0);
    do_alloc('h3300, 7, 'hC2C2, 1);
    do_alloc('h4400, 9, 'hD3D3, 0);
    show_all();
    // R3 stall when full
    do_alloc('h5500, 1, 'hEEEE, 1);
    show_all();
    // R4/R5: data announcing 2 acks, then two peer acks
    do_upd(0, 2);
    do_upd(0, -1);
    do_upd(0, -1);
    step();
    // R5 zero-ack update posts at once; R6 order
    do_upd(1, 0);
    step();
    trig_pop = 1; step();
    trig_pop = 1; step();
    // R6 pop on empty ignored
    trig_pop = 1; step();
    step();
    // R7 collision on slot 2 with count made to hit zero
    do_upd(2, 1);
    upd_valid = 1; upd_slot = 2; upd_acks = -1;
    dealloc_valid = 1; dealloc_slot = 2; rd_slot = 2;
    step();
    step();
    // R4 update to free slot ignored
    do_upd(2, 0);
    step();
    // R9 state write on valid and free slot
    st_wr_valid = 1; st_wr_slot = 1; st_wr_state = 4'hC; rd_slot = 1; step();
    st_wr_valid = 1; st_wr_slot = 2; st_wr_state = 4'hF; rd_slot = 2; step();
    // R11 slot freed and requested same cycle
    dealloc_valid = 1; dealloc_slot = 3;
    alloc_req = 1; alloc_addr = 16'h6600; alloc_state = 2; alloc_data = 32'h1234; alloc_dirty = 1;
    step();
    do_alloc('h7700, 4, 'h5678, 0);
    do_alloc('h8800, 6, 'h9ABC, 1);
    show_all();
    // R10 wrap
    do_upd(1, -31);
    do_upd(1, -1);
    do_upd(1, 32);
    step();
    // R5 nonzero result posts nothing; push and pop together
    do_upd(3, 1);
    upd_valid = 1; upd_slot = 3; upd_acks = -1; trig_pop = 1;
    step();
    trig_pop = 1; step();
    step();
    // R7 plain deallocate
    dealloc_valid = 1; dealloc_slot = 0; rd_slot = 0; step();
    show_all();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule